// File: doc/BRIEF.md
# Channel-Status Flag and Block-Start Extractor

This block sits behind a digital audio interface decoder. For each decoded subframe it receives a strobe, a tag that says whether the subframe is left or right, a marker for the block-start preamble, and that subframe's channel-status (C) bit and user (U) bit. It produces two serial outputs that carry the C and U bits in arrival order, left then right. The bit stream is delayed by a fixed number of bit-clock ticks, so that it lines up with the re-timed audio output frame.

On the same delayed stream, the block raises a block-start window. The window goes high when a block begins and lasts 32 frame periods out of the 192-frame block. The block also assembles byte 0 of the left channel's status block. It decodes two dedicated flags from that byte: pre-emphasis, and audio versus non-audio. The decode rule for the emphasis flag depends on whether bit 0 of the byte marks the professional layout or the consumer layout. The flags change only when a complete 192-frame block has been received.

All logic runs on one clock. The bit clock arrives as a one-cycle enable, and frame timing is taken from the subframe strobes.

Top module: `cs_flag_extractor`

## Requirements
- R1: While `rst_n` is low at a clock edge, all five outputs are low after that edge.
- R2: The C and U bits of a subframe appear on `cs_ser` and `ur_ser` at the 16th `bit_en` tick after the tick on which the subframe was strobed. They hold that value until the next subframe emerges. Left and right keep their arrival order.
- R3: A cycle with `bit_en` low neither moves the delay nor changes any output. A strobe given without `bit_en` is dropped.
- R4: `blk_start` rises when a left subframe that carries the block marker emerges from the delay. It falls when the 32nd following left subframe emerges, so it is high for exactly 32 frame periods.
- R5: A left subframe with the block marker that arrives partway through a block restarts the window, the frame count and byte 0 assembly.
- R6: Byte 0 is built from the C bits of the first 8 left subframes of a block. The block-start frame supplies bit 0, and each following frame supplies the next higher bit. Right-channel C bits never reach the flags.
- R7: The flags change only when the right subframe of frame 191 of a tracked block emerges. A block that is cut short leaves the flags unchanged.
- R8: When byte-0 bit 0 is 1 (professional layout), `emph_flag` is 1 only for bit2=1, bit3=1 and bit4=0.
- R9: When byte-0 bit 0 is 0 (consumer layout), `emph_flag` is 1 only for bit3=1, bit4=0 and bit5=0.
- R10: `nonaudio_flag` equals byte-0 bit 1 in both layouts: 0 means PCM audio, 1 means other data.
- R11: After frame 191, tracking stops. There are no further flag updates and no window until a new block marker arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle bit-clock tick |
| sf_valid | input | 1 | Subframe strobe, valid only together with `bit_en` |
| sf_right | input | 1 | 1 = right-channel subframe, 0 = left |
| sf_block | input | 1 | Subframe carries the block-start preamble (meaningful on left only) |
| sf_cbit | input | 1 | Channel-status bit of the subframe |
| sf_ubit | input | 1 | User bit of the subframe |
| cs_ser | output | 1 | Serial channel-status output, delayed |
| ur_ser | output | 1 | Serial user-bit output, delayed |
| blk_start | output | 1 | Block-start window, 32 frames long |
| emph_flag | output | 1 | Pre-emphasis flag decoded from left byte 0 |
| nonaudio_flag | output | 1 | Non-audio flag decoded from left byte 0 |

## Verification
A corrupted delay stage shows up on `cs_ser`/`ur_ser` at exactly the 16th tick after the strobe. It also displaces the block-start edge by whole subframes, and the bench compares every output after every tick, so the error is seen at once. A wrong frame count moves the `blk_start` fall away from frame 32, and the mismatch appears at that frame. A wrong bit index or a wrong layout decode shows only as a wrong flag value. That error is visible only after the right subframe of frame 191, so the bench runs full blocks with byte values that set each decode branch. A truncated block checks that no update happens early.

// File: rtl/csx_pkg.sv
// Shared types and the byte-0 flag decode for the channel-status extractor.
// Assumes byte 0 is stored with bit 0 being the first C bit received.
package csx_pkg;

    // One decoded subframe as it travels through the delay line.
    typedef struct packed {
        logic vld;    // entry holds a subframe
        logic right;  // 1 = right channel
        logic blk;    // block-start preamble
        logic c;      // channel-status bit
        logic u;      // user bit
    } sf_t;

    // Returns {emphasis, non_audio} for a status byte 0.
    function automatic logic [1:0] decode_byte0(input logic [7:0] b);
        logic emph;
        if (b[0]) begin
            emph = b[2] & b[3] & ~b[4];
        end else begin
            emph = b[3] & ~b[4] & ~b[5];
        end
        return {emph, b[1]};
    endfunction

endpackage

// File: rtl/csx_sf_delay.sv
// Fixed delay of DEPTH bit ticks for subframe entries.
// Assumes a new entry is presented only on a tick; the output is the last stage.
module csx_sf_delay
    import csx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  sf_t  din,
    output sf_t  dout
);

    sf_t stage [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            // Capture the incoming entry on each tick.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage[i] <= '0;
                end else if (tick) begin
                    stage[i] <= din;
                end
            end
        end else begin : g_body
            // Move the entry one stage on each tick.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage[i] <= '0;
                end else if (tick) begin
                    stage[i] <= stage[i-1];
                end
            end
        end
    end

    assign dout = stage[DEPTH-1];

endmodule

// File: rtl/csx_frame_track.sv
// Tracks frames of the delayed stream. It drives the block-start window, the
// byte-0 bit write strobes and the end-of-block commit.
// Assumes ev is a single-cycle strobe for each subframe that emerges from the delay.
module csx_frame_track
    import csx_pkg::*;
#(
    parameter int BLOCK_FRAMES = 192,
    parameter int WIN_FRAMES   = 32,
    parameter int BYTE_BITS    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ev,
    input  sf_t                          sf,
    output logic                         blk_win,
    output logic                         byte_we,
    output logic [$clog2(BYTE_BITS)-1:0] byte_idx,
    output logic                         commit
);

    localparam int FCW = $clog2(BLOCK_FRAMES + 1);
    localparam int IW  = $clog2(BYTE_BITS);

    logic [FCW-1:0] frame_q;
    logic [FCW-1:0] frame_nx;
    logic           tracking_q;
    logic           left_ev;

    // Classify the event and work out the index of the next frame.
    always_comb begin
        left_ev  = ev & ~sf.right;
        frame_nx = frame_q + 1'b1;
    end

    // Frame counter, tracking state and block-start window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q    <= '0;
            tracking_q <= 1'b0;
            blk_win    <= 1'b0;
        end else if (left_ev) begin
            if (sf.blk) begin
                frame_q    <= '0;
                tracking_q <= 1'b1;
                blk_win    <= 1'b1;
            end else if (tracking_q) begin
                frame_q <= frame_nx;
                if (frame_nx == FCW'(WIN_FRAMES)) begin
                    blk_win <= 1'b0;
                end
                if (frame_nx == FCW'(BLOCK_FRAMES)) begin
                    tracking_q <= 1'b0;
                end
            end
        end
    end

    // Write strobe and bit index for the byte-0 assembly.
    always_comb begin
        byte_we  = 1'b0;
        byte_idx = '0;
        if (left_ev) begin
            if (sf.blk) begin
                byte_we = 1'b1;
            end else if (tracking_q && (frame_nx < FCW'(BYTE_BITS))) begin
                byte_we  = 1'b1;
                byte_idx = IW'(frame_nx);
            end
        end
    end

    // Commit once the last right subframe of a full block has emerged.
    always_comb begin
        commit = ev & sf.right & tracking_q & (frame_q == FCW'(BLOCK_FRAMES - 1));
    end

    // R4: the window is open only inside its first WIN_FRAMES tracked frames.
    p_win_inside_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        blk_win |-> (tracking_q && (frame_q < FCW'(WIN_FRAMES))));

    // R7: a commit never falls inside the block-start window.
    p_commit_outside_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !blk_win);

endmodule

// File: rtl/csx_flag_decode.sv
// Assembles left-channel status byte 0 and latches the decoded flags at commit.
// Assumes byte bits are written before the commit of the same block.
module csx_flag_decode
    import csx_pkg::*;
#(
    parameter int BYTE_BITS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         byte_we,
    input  logic [$clog2(BYTE_BITS)-1:0] byte_idx,
    input  logic                         cbit,
    input  logic                         commit,
    output logic                         emph,
    output logic                         nonaudio
);

    logic [BYTE_BITS-1:0] byte_q;
    logic [1:0]           dec;

    // Store one C bit at its position in byte 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (byte_we) begin
            byte_q[byte_idx] <= cbit;
        end
    end

    // Decode the layout-dependent flags from the assembled byte.
    always_comb begin
        dec = decode_byte0(byte_q[7:0]);
    end

    // Latch the flags only at the end of a complete block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emph     <= 1'b0;
            nonaudio <= 1'b0;
        end else if (commit) begin
            emph     <= dec[1];
            nonaudio <= dec[0];
        end
    end

    // R7: the flags hold in every cycle without a commit.
    p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(emph) && $stable(nonaudio)));

endmodule

// File: rtl/cs_flag_extractor.sv
// Top level: delays the subframe stream, drives the serial C/U outputs, and
// extracts the block-start window and the byte-0 flags.
// Assumes sf_valid is asserted only together with bit_en.
module cs_flag_extractor
    import csx_pkg::*;
#(
    parameter int DELAY_TICKS  = 16,
    parameter int BLOCK_FRAMES = 192,
    parameter int WIN_FRAMES   = 32,
    parameter int BYTE_BITS    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic sf_valid,
    input  logic sf_right,
    input  logic sf_block,
    input  logic sf_cbit,
    input  logic sf_ubit,
    output logic cs_ser,
    output logic ur_ser,
    output logic blk_start,
    output logic emph_flag,
    output logic nonaudio_flag
);

    localparam int IW = $clog2(BYTE_BITS);

    sf_t           sf_in;
    sf_t           sf_dly;
    logic          ev;
    logic          byte_we;
    logic [IW-1:0] byte_idx;
    logic          commit;

    // Pack the input subframe into a delay entry.
    always_comb begin
        sf_in.vld   = sf_valid;
        sf_in.right = sf_right;
        sf_in.blk   = sf_block;
        sf_in.c     = sf_cbit;
        sf_in.u     = sf_ubit;
    end

    csx_sf_delay #(
        .DEPTH (DELAY_TICKS)
    ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_en),
        .din   (sf_in),
        .dout  (sf_dly)
    );

    // A delayed subframe emerges on the tick that pushes it out of the last stage.
    always_comb begin
        ev = bit_en & sf_dly.vld;
    end

    // Serial C and U outputs, updated as each subframe emerges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_ser <= 1'b0;
            ur_ser <= 1'b0;
        end else if (ev) begin
            cs_ser <= sf_dly.c;
            ur_ser <= sf_dly.u;
        end
    end

    csx_frame_track #(
        .BLOCK_FRAMES (BLOCK_FRAMES),
        .WIN_FRAMES   (WIN_FRAMES),
        .BYTE_BITS    (BYTE_BITS)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .sf       (sf_dly),
        .blk_win  (blk_start),
        .byte_we  (byte_we),
        .byte_idx (byte_idx),
        .commit   (commit)
    );

    csx_flag_decode #(
        .BYTE_BITS (BYTE_BITS)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_we  (byte_we),
        .byte_idx (byte_idx),
        .cbit     (sf_dly.c),
        .commit   (commit),
        .emph     (emph_flag),
        .nonaudio (nonaudio_flag)
    );

    // R1: reset clears every output.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!cs_ser && !ur_ser && !blk_start && !emph_flag && !nonaudio_flag));

    // R3: nothing changes on a cycle without a bit tick.
    p_hold_without_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(cs_ser) && $stable(ur_ser) && $stable(blk_start)
                     && $stable(emph_flag) && $stable(nonaudio_flag)));

endmodule

// File: tb/test_cs_flag_extractor.sv
module test_cs_flag_extractor;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, sf_valid = 1'b0, sf_right = 1'b0, sf_block = 1'b0;
    logic sf_cbit = 1'b0, sf_ubit = 1'b0;
    logic cs_ser, ur_ser, blk_start, emph_flag, nonaudio_flag;

    int n_vec = 0;
    int n_bad = 0;
    string flag_tag = "R1";

    // Reference model state.
    logic [3:0] rv [16];
    logic       ex_cs = 0, ex_ur = 0, ex_blk = 0, ex_emph = 0, ex_na = 0;
    logic [7:0] m_byte = 0;
    int         m_frame = 0;
    bit         m_track = 0;
    int         tptr = 0;
    bit         rvld [16];

    always #4 clk = ~clk;

    cs_flag_extractor i_cs_flag_extractor (
        .clk, .rst_n, .bit_en, .sf_valid, .sf_right, .sf_block,
        .sf_cbit, .sf_ubit, .cs_ser, .ur_ser, .blk_start,
        .emph_flag, .nonaudio_flag
    );

    // Expected {emph, nonaudio} from the rules in R8, R9 and R10.
    function automatic logic [1:0] exp_flags(input logic [7:0] b);
        logic e;
        if (b[0] == 1'b1) e = (b[2] == 1'b1) && (b[3] == 1'b1) && (b[4] == 1'b0);
        else              e = (b[3] == 1'b1) && (b[4] == 1'b0) && (b[5] == 1'b0);
        return {e, b[1]};
    endfunction

    task automatic cmp(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        cmp("R2 cs_ser", cs_ser, ex_cs);
        cmp("R2 ur_ser", ur_ser, ex_ur);
        cmp("R4 R5 blk_start", blk_start, ex_blk);
        cmp({flag_tag, " emph_flag"}, emph_flag, ex_emph);
        cmp({flag_tag, " nonaudio_flag"}, nonaudio_flag, ex_na);
    endtask

    // Apply one emerging entry {right, blk, c, u} to the expected outputs.
    task automatic model_emit(input logic [3:0] e);
        logic [1:0] f;
        ex_cs = e[1];
        ex_ur = e[0];
        if (e[3] == 1'b0) begin
            if (e[2] == 1'b1) begin
                m_frame = 0; m_track = 1; ex_blk = 1; m_byte[0] = e[1];
            end else if (m_track) begin
                m_frame++;
                if (m_frame == 32) ex_blk = 0;
                if (m_frame < 8) m_byte[m_frame] = e[1];
                if (m_frame == 192) m_track = 0;
            end
        end else if (m_track && m_frame == 191) begin
            f = exp_flags(m_byte);
            ex_emph = f[1];
            ex_na = f[0];
        end
    endtask

    // One bit tick, optionally carrying a subframe; idle cycles are sprinkled in (R3).
    task automatic tick(input bit sf, input bit rt, input bit bk, input bit c, input bit u);
        int idles;
        idles = (($urandom % 4) == 0) ? 1 + ($urandom % 2) : 0;
        for (int i = 0; i < idles; i++) begin
            @(negedge clk);
            check_all();
            bit_en = 0; sf_valid = (i == 0) ? $urandom % 2 : 0; // R3: strobe without tick dropped
            sf_right = 0; sf_block = 1; sf_cbit = 1; sf_ubit = 1;
        end
        @(negedge clk);
        check_all();
        bit_en = 1; sf_valid = sf; sf_right = rt; sf_block = bk; sf_cbit = c; sf_ubit = u;
        if (rvld[tptr]) model_emit(rv[tptr]);
        rvld[tptr] = sf;
        rv[tptr] = {rt, bk, c, u};
        tptr = (tptr + 1) % 16;
    endtask

    task automatic subframe(input bit rt, input bit bk, input bit c, input bit u);
        tick(1, rt, bk, c, u);
        for (int i = 0; i < 31; i++) tick(0, 0, 0, 0, 0);
    endtask

    // Send frames of a block; byte0 goes on the left C bits of frames 0..7 and
    // its complement on the right (R6: right bits must not count).
    task automatic run_block(input logic [7:0] b0, input int nfr, input bit start_b);
        for (int f = 0; f < nfr; f++) begin
            logic cl, cr;
            cl = (f < 8) ? b0[f] : 1'($urandom);
            cr = (f < 8) ? ~b0[f] : 1'($urandom);
            subframe(0, start_b && (f == 0), cl, 1'($urandom));
            subframe(1, 0, cr, 1'($urandom));
        end
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        void'($urandom(32'd1701));
        for (int i = 0; i < 16; i++) begin rvld[i] = 0; rv[i] = '0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_all(); // R1 reset state
        rst_n = 1;
        flag_tag = "R6 R9 R10";
        run_block(8'h0A, 192, 1);   // consumer, emphasis, non-audio
        flag_tag = "R8 R10";
        run_block(8'h0D, 192, 1);   // professional, emphasis, PCM
        flag_tag = "R5 R7";
        run_block(8'h01, 100, 1);   // truncated: flags must stay
        flag_tag = "R8";
        run_block(8'h1D, 192, 1);   // professional, bit4 set: no emphasis
        flag_tag = "R9 R6";
        rb = $urandom;
        run_block(rb, 192, 1);      // random byte
        flag_tag = "R9 R11";
        run_block(8'h28, 192, 1);   // consumer, bit5 set: no emphasis
        run_block(8'hFF, 40, 0);    // no block marker: no window, no update
        @(negedge clk);
        check_all();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule